// File: doc/BRIEF.md
# Iterative Prefix-Class Lookup Sequencer

This block drives a longest-prefix-match search for a 32-bit destination address against a set-associative route store that sits outside it. Route prefixes are split by length into a small number of classes. Each class has its own index window inside the address. A search probes the classes one after another, starting with the class of longest prefixes. Each probe carries the class number, the index taken from the address for that class, the class length window and a per-bank enable vector. The external array and match arbiter answer each probe with a hit flag and a next hop. The first class that hits supplies the answer, so a search normally ends early. A mode input forces every class to be probed, which gives a fixed worst-case latency; the answer still comes from the longest class that hit.

Every bank of the route store carries a 2-bit occupancy code. A probe enables only the banks whose code says they may hold the class being searched, so the other banks can stay powered down. A class for which no bank is enabled is not probed at all: it is counted as searched and treated as a miss. The class windows and the bank codes can be programmed through plain write ports.

There are three valid/ready streams. The request stream carries the address. The probe stream carries each class probe out, and its response stream carries the answer back in. The result stream carries the hit flag, the next hop and the number of classes searched. A stream holds its payload while its valid is high and its ready is low. A new request is accepted only when the sequencer is idle. No further request is accepted until the result has been taken, so back-pressure on the result stream stalls the request stream.

Top module: `lpm_class_walker`

## Requirements
- R1: `req_ready` is high only while idle, meaning no probe, response or result is pending. The address is captured when a request is accepted, and `probe_addr` holds it unchanged until the result is taken.
- R2: Classes are probed in increasing class number, and class 0 holds the longest prefixes. Take the class index LSB position p, with bit 1 as the address MSB, clamped to the range IDX_W..32. The probe index is then `(addr >> (32 - p))` truncated to IDX_W bits.
- R3: After reset the classes are set as (lower length, index LSB position, upper length): class 0 (21, 21, 32), class 1 (17, 17, 20), class 2 (8, 16, 16). `probe_lo_len` and `probe_hi_len` carry the lower and upper lengths of the class being probed.
- R4: With `force_all` low, the search stops at the first hit. `res_probes` equals the number of the hitting class plus one.
- R5: With `force_all` high at request acceptance, all NCLS classes are searched. The result comes from the lowest-numbered class that hit, and `res_probes` is NCLS.
- R6: If no class hits, `res_hit` is 0, `res_nexthop` is 0 and `res_probes` is NCLS.
- R7: The bank codes are 00 empty, 01 longest class only, 10 shorter classes only and 11 mixed, and all banks reset to 11. A class 0 probe enables banks coded 01 or 11. Any other class enables banks coded 10 or 11.
- R8: A class whose bank enable vector would be all zero issues no probe. It counts as one searched class that missed.
- R9: A class write (`ccfg_we`) replaces the lower length, index position and upper length of class `ccfg_sel`, and the next search uses the new values.
- R10: While `probe_valid` is high and `probe_ready` is low, the probe holds its class, index and enables.
- R11: While `res_valid` is high and `res_ready` is low, the result holds and no request is accepted.
- R12: `rsp_ready` is high only between the acceptance of a probe and its response, and never while `probe_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_all | input | 1 | Probe every class; sampled at request acceptance |
| ccfg_we | input | 1 | Class window write strobe |
| ccfg_sel | input | CLS_W | Class to write |
| ccfg_lo | input | 6 | New lower prefix length |
| ccfg_ixlsb | input | 6 | New index LSB position (1 = MSB) |
| ccfg_hi | input | 6 | New upper prefix length |
| bcode_we | input | 1 | Bank code write strobe |
| bcode_bank | input | BANK_W | Bank to write |
| bcode_val | input | 2 | New bank occupancy code |
| req_valid | input | 1 | Search request valid |
| req_ready | output | 1 | Search request ready |
| req_addr | input | 32 | Destination address |
| probe_valid | output | 1 | Class probe valid |
| probe_ready | input | 1 | Class probe ready |
| probe_class | output | CLS_W | Class being probed |
| probe_index | output | IDX_W | Set index for the class |
| probe_addr | output | 32 | Held search address for tag compare |
| probe_lo_len | output | 6 | Lower prefix length of the class |
| probe_hi_len | output | 6 | Upper prefix length of the class |
| probe_bank_en | output | NBANK | Banks enabled for this probe |
| rsp_valid | input | 1 | Probe response valid |
| rsp_ready | output | 1 | Probe response ready |
| rsp_hit | input | 1 | Probe matched a prefix |
| rsp_nexthop | input | NH_W | Next hop of the matched prefix |
| res_valid | output | 1 | Search result valid |
| res_ready | input | 1 | Search result ready |
| res_hit | output | 1 | Some class hit |
| res_nexthop | output | NH_W | Next hop, zero on miss |
| res_probes | output | CNT_W | Number of classes searched |

## Verification
The hardest case to reach from the ports is a class skipped because no bank may hold it. It only arises after the bank codes are rewritten so that every bank is either empty or reserved for the longest class. In that state the response model is set to hit on the skipped class, and the bench checks that the search still misses. It also checks that only one probe appears on the stream while `res_probes` reports all classes. Back-pressure on the probe and result streams in the same search is reached by holding the readies low for several cycles, while the bench watches that the payloads stay stable and that requests stay blocked.

// File: rtl/lpm_walk_pkg.sv
package lpm_walk_pkg;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'b00,
    BK_LONG  = 2'b01,
    BK_SHORT = 2'b10,
    BK_MIXED = 2'b11
  } bank_code_e;

  typedef struct packed {
    logic [LEN_W-1:0] lo;
    logic [LEN_W-1:0] ixlsb;
    logic [LEN_W-1:0] hi;
  } class_cfg_t;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_PROBE = 2'd1,
    W_WAIT  = 2'd2,
    W_DONE  = 2'd3
  } walk_state_e;

  // Reset windows: class 0 longest, last class shortest (expanded to its index).
  function automatic class_cfg_t default_cfg(input int c);
    class_cfg_t r;
    if (c == 0) begin
      r.lo = 6'd21; r.ixlsb = 6'd21; r.hi = 6'd32;
    end else if (c == 1) begin
      r.lo = 6'd17; r.ixlsb = 6'd17; r.hi = 6'd20;
    end else begin
      r.lo = 6'd8;  r.ixlsb = 6'd16; r.hi = 6'd16;
    end
    return r;
  endfunction
endpackage

// File: rtl/lpm_class_regs.sv
module lpm_class_regs
  import lpm_walk_pkg::*;
#(
  parameter int NCLS  = 3,
  parameter int NBANK = 4,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ccfg_we,
  input  logic [CLS_W-1:0]       ccfg_sel,
  input  logic [LEN_W-1:0]       ccfg_lo,
  input  logic [LEN_W-1:0]       ccfg_ixlsb,
  input  logic [LEN_W-1:0]       ccfg_hi,
  input  logic                   bcode_we,
  input  logic [BANK_W-1:0]      bcode_bank,
  input  logic [1:0]             bcode_val,
  input  logic [CLS_W-1:0]       cls_i,
  output class_cfg_t             cfg_o,
  output logic [NBANK-1:0][1:0]  codes_o
);
  class_cfg_t            cfg_q [NCLS];
  logic [NBANK-1:0][1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) cfg_q[c] <= default_cfg(c);
    end else if (ccfg_we) begin
      for (int c = 0; c < NCLS; c++) begin
        if (ccfg_sel == CLS_W'(c)) cfg_q[c] <= '{lo: ccfg_lo, ixlsb: ccfg_ixlsb, hi: ccfg_hi};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) code_q[b] <= BK_MIXED;
    end else if (bcode_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bcode_bank == BANK_W'(b)) code_q[b] <= bcode_val;
      end
    end
  end

  always_comb begin
    cfg_o = cfg_q[0];
    for (int c = 0; c < NCLS; c++) begin
      if (cls_i == CLS_W'(c)) cfg_o = cfg_q[c];
    end
  end

  assign codes_o = code_q;
endmodule

// File: rtl/lpm_probe_former.sv
module lpm_probe_former
  import lpm_walk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int IDX_W = 12
) (
  input  logic [31:0]            addr_i,
  input  class_cfg_t             cfg_i,
  input  logic                   is_long_i,
  input  logic [NBANK-1:0][1:0]  codes_i,
  output logic [IDX_W-1:0]       index_o,
  output logic [NBANK-1:0]       bank_en_o
);
  localparam logic [LEN_W-1:0] P_MIN = LEN_W'(IDX_W);
  localparam logic [LEN_W-1:0] P_MAX = LEN_W'(32);

  logic [LEN_W-1:0] pos;
  logic [LEN_W-1:0] sh;

  always_comb begin
    if (cfg_i.ixlsb < P_MIN)      pos = P_MIN;
    else if (cfg_i.ixlsb > P_MAX) pos = P_MAX;
    else                          pos = cfg_i.ixlsb;
    sh      = P_MAX - pos;
    index_o = IDX_W'(addr_i >> sh);
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic holds_long, holds_short;
    assign holds_long  = (codes_i[b] == BK_LONG)  || (codes_i[b] == BK_MIXED);
    assign holds_short = (codes_i[b] == BK_SHORT) || (codes_i[b] == BK_MIXED);
    assign bank_en_o[b] = is_long_i ? holds_long : holds_short;
  end
endmodule

// File: rtl/lpm_walk_fsm.sv
module lpm_walk_fsm
  import lpm_walk_pkg::*;
#(
  parameter int NCLS = 3,
  parameter int NH_W = 16,
  localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int CNT_W = $clog2(NCLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_all,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              bank_none,
  output logic              probe_valid,
  input  logic              probe_ready,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_hit,
  input  logic [NH_W-1:0]   rsp_nexthop,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [NH_W-1:0]   res_nexthop,
  output logic [CNT_W-1:0]  res_probes,
  output logic [CLS_W-1:0]  cls_o,
  output logic [31:0]       addr_o
);
  localparam logic [CLS_W-1:0] LAST = CLS_W'(NCLS - 1);

  walk_state_e      st;
  logic [CLS_W-1:0] cls_q;
  logic [31:0]      addr_q;
  logic             mode_q, found_q;
  logic [NH_W-1:0]  nh_q;
  logic [CNT_W-1:0] probes_q;

  logic step_fire, step_hit, finish;

  always_comb begin
    step_fire = ((st == W_PROBE) && bank_none) || ((st == W_WAIT) && rsp_valid);
    step_hit  = (st == W_WAIT) && rsp_valid && rsp_hit;
    finish    = (step_hit && !mode_q) || (cls_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= W_IDLE;
      cls_q    <= '0;
      addr_q   <= '0;
      mode_q   <= 1'b0;
      found_q  <= 1'b0;
      nh_q     <= '0;
      probes_q <= '0;
    end else begin
      case (st)
        W_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          mode_q  <= force_all;
          cls_q   <= '0;
          found_q <= 1'b0;
          nh_q    <= '0;
          st      <= W_PROBE;
        end
        W_PROBE, W_WAIT: begin
          if (step_fire) begin
            if (step_hit && !found_q) begin
              found_q <= 1'b1;
              nh_q    <= rsp_nexthop;
            end
            if (finish) begin
              probes_q <= CNT_W'(cls_q) + CNT_W'(1);
              st       <= W_DONE;
            end else begin
              cls_q <= cls_q + CLS_W'(1);
              st    <= W_PROBE;
            end
          end else if ((st == W_PROBE) && probe_ready) begin
            st <= W_WAIT;
          end
        end
        W_DONE: if (res_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == W_IDLE);
  assign probe_valid = (st == W_PROBE) && !bank_none;
  assign rsp_ready   = (st == W_WAIT);
  assign res_valid   = (st == W_DONE);
  assign res_hit     = found_q;
  assign res_nexthop = nh_q;
  assign res_probes  = probes_q;
  assign cls_o       = cls_q;
  assign addr_o      = addr_q;
endmodule

// File: rtl/lpm_class_walker.sv
module lpm_class_walker
  import lpm_walk_pkg::*;
#(
  parameter int NCLS  = 3,
  parameter int NBANK = 4,
  parameter int IDX_W = 12,
  parameter int NH_W  = 16,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int CNT_W  = $clog2(NCLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_all,
  input  logic              ccfg_we,
  input  logic [CLS_W-1:0]  ccfg_sel,
  input  logic [5:0]        ccfg_lo,
  input  logic [5:0]        ccfg_ixlsb,
  input  logic [5:0]        ccfg_hi,
  input  logic              bcode_we,
  input  logic [BANK_W-1:0] bcode_bank,
  input  logic [1:0]        bcode_val,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  output logic              probe_valid,
  input  logic              probe_ready,
  output logic [CLS_W-1:0]  probe_class,
  output logic [IDX_W-1:0]  probe_index,
  output logic [31:0]       probe_addr,
  output logic [5:0]        probe_lo_len,
  output logic [5:0]        probe_hi_len,
  output logic [NBANK-1:0]  probe_bank_en,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_hit,
  input  logic [NH_W-1:0]   rsp_nexthop,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [NH_W-1:0]   res_nexthop,
  output logic [CNT_W-1:0]  res_probes
);
  class_cfg_t            cur_cfg;
  logic [NBANK-1:0][1:0] codes;
  logic [CLS_W-1:0]      cls;
  logic [31:0]           addr;
  logic [NBANK-1:0]      bank_en;

  lpm_class_regs #(.NCLS(NCLS), .NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ccfg_we(ccfg_we), .ccfg_sel(ccfg_sel), .ccfg_lo(ccfg_lo),
    .ccfg_ixlsb(ccfg_ixlsb), .ccfg_hi(ccfg_hi),
    .bcode_we(bcode_we), .bcode_bank(bcode_bank), .bcode_val(bcode_val),
    .cls_i(cls), .cfg_o(cur_cfg), .codes_o(codes)
  );

  lpm_probe_former #(.NBANK(NBANK), .IDX_W(IDX_W)) u_form (
    .addr_i(addr), .cfg_i(cur_cfg), .is_long_i(cls == '0),
    .codes_i(codes), .index_o(probe_index), .bank_en_o(bank_en)
  );

  lpm_walk_fsm #(.NCLS(NCLS), .NH_W(NH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .force_all(force_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .bank_none(bank_en == '0),
    .probe_valid(probe_valid), .probe_ready(probe_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_nexthop(rsp_nexthop),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_nexthop(res_nexthop), .res_probes(res_probes),
    .cls_o(cls), .addr_o(addr)
  );

  assign probe_class   = cls;
  assign probe_addr    = addr;
  assign probe_lo_len  = cur_cfg.lo;
  assign probe_hi_len  = cur_cfg.hi;
  assign probe_bank_en = bank_en;
endmodule

// File: rtl/lpm_class_walker_chk.sv
module lpm_class_walker_chk #(
  parameter int NCLS  = 3,
  parameter int NBANK = 4,
  parameter int IDX_W = 12,
  parameter int NH_W  = 16,
  localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int CNT_W = $clog2(NCLS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              probe_valid,
  input logic              probe_ready,
  input logic [CLS_W-1:0]  probe_class,
  input logic [IDX_W-1:0]  probe_index,
  input logic [31:0]       probe_addr,
  input logic [NBANK-1:0]  probe_bank_en,
  input logic              rsp_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic [NH_W-1:0]   res_nexthop,
  input logic [CNT_W-1:0]  res_probes
);
  assert_busy_blocks_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid || rsp_ready || res_valid) |-> !req_ready);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(probe_addr));

  assert_probe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_ready) |=> (probe_valid && $stable(probe_class)
      && $stable(probe_index) && $stable(probe_bank_en)));

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_hit)
      && $stable(res_nexthop) && $stable(res_probes)));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_nexthop == '0 && res_probes == CNT_W'(NCLS)));

  assert_probe_has_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> (probe_bank_en != '0));

  assert_probe_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_probes >= CNT_W'(1) && res_probes <= CNT_W'(NCLS)));

  assert_one_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_valid && rsp_ready));
endmodule

bind lpm_class_walker lpm_class_walker_chk #(
  .NCLS(NCLS), .NBANK(NBANK), .IDX_W(IDX_W), .NH_W(NH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .probe_valid(probe_valid), .probe_ready(probe_ready),
  .probe_class(probe_class), .probe_index(probe_index),
  .probe_addr(probe_addr), .probe_bank_en(probe_bank_en),
  .rsp_ready(rsp_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_hit(res_hit), .res_nexthop(res_nexthop), .res_probes(res_probes)
);

// File: tb/lpm_class_walker_tb.sv
module lpm_class_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_all = 1'b0;
  logic        ccfg_we = 1'b0;
  logic [1:0]  ccfg_sel = '0;
  logic [5:0]  ccfg_lo = '0, ccfg_ixlsb = '0, ccfg_hi = '0;
  logic        bcode_we = 1'b0;
  logic [1:0]  bcode_bank = '0, bcode_val = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        probe_valid, probe_ready = 1'b1;
  logic [1:0]  probe_class;
  logic [11:0] probe_index;
  logic [31:0] probe_addr;
  logic [5:0]  probe_lo_len, probe_hi_len;
  logic [3:0]  probe_bank_en;
  logic        rsp_valid = 1'b0, rsp_ready, rsp_hit = 1'b0;
  logic [15:0] rsp_nexthop = '0;
  logic        res_valid, res_ready = 1'b0, res_hit;
  logic [15:0] res_nexthop;
  logic [1:0]  res_probes;

  int checks = 0, errors = 0, cycles = 0;

  // bench-side model of the programmable state
  int          b_lo [3] = '{21, 17, 8};
  int          b_ix [3] = '{21, 17, 16};
  int          b_hi [3] = '{32, 20, 16};
  logic [3:0]  en_long = 4'b1111, en_short = 4'b1111;

  lpm_class_walker u_dut (
    .clk(clk), .rst_n(rst_n), .force_all(force_all),
    .ccfg_we(ccfg_we), .ccfg_sel(ccfg_sel), .ccfg_lo(ccfg_lo),
    .ccfg_ixlsb(ccfg_ixlsb), .ccfg_hi(ccfg_hi),
    .bcode_we(bcode_we), .bcode_bank(bcode_bank), .bcode_val(bcode_val),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .probe_valid(probe_valid), .probe_ready(probe_ready),
    .probe_class(probe_class), .probe_index(probe_index),
    .probe_addr(probe_addr), .probe_lo_len(probe_lo_len),
    .probe_hi_len(probe_hi_len), .probe_bank_en(probe_bank_en),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_nexthop(rsp_nexthop),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
    .res_nexthop(res_nexthop), .res_probes(res_probes)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_index(input logic [31:0] a, input int ix);
    int p;
    p = (ix < 12) ? 12 : ((ix > 32) ? 32 : ix);
    return 12'(a >> (32 - p));
  endfunction

  task automatic run_search(input logic [31:0] a, input logic fa, input logic [2:0] mask,
                            input int pstall, input int rstall,
                            output logic got_hit, output logic [15:0] got_nh,
                            output logic [1:0] got_probes, output int seen);
    int prev = -1;
    bit pend = 0;
    int pcls = 0;
    int stcls = -1;
    seen = 0; got_hit = 0; got_nh = '0; got_probes = '0;
    @(negedge clk);
    force_all = fa; req_addr = a; req_valid = 1'b1;
    chk("R1 req_ready idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 80; k++) begin
      rsp_valid = 1'b0;
      if (res_valid) begin
        if (rstall > 0) begin
          res_ready = 1'b0;
          chk("R11 no accept while result held", 32'(req_ready), 32'd0);
          rstall--;
        end else begin
          res_ready = 1'b1;
          got_hit = res_hit; got_nh = res_nexthop; got_probes = res_probes;
          @(negedge clk);
          res_ready = 1'b0;
          break;
        end
      end else if (probe_valid) begin
        if (pstall > 0) begin
          probe_ready = 1'b0;
          if (stcls < 0) stcls = int'(probe_class);
          chk("R10 probe class held", 32'(probe_class), 32'(stcls));
          pstall--;
        end else begin
          probe_ready = 1'b1;
          pcls = int'(probe_class);
          chk("R2 class order", 32'(pcls > prev), 32'd1);
          chk("R2 probe index", 32'(probe_index), 32'(exp_index(a, b_ix[pcls])));
          chk("R1 probe addr", probe_addr, a);
          chk("R3 lo len", 32'(probe_lo_len), 32'(b_lo[pcls]));
          chk("R3 hi len", 32'(probe_hi_len), 32'(b_hi[pcls]));
          chk("R7 bank enable", 32'(probe_bank_en), 32'((pcls == 0) ? en_long : en_short));
          chk("R1 busy blocks req", 32'(req_ready), 32'd0);
          prev = pcls; seen++; pend = 1;
        end
      end else if (pend) begin
        chk("R12 rsp_ready", 32'(rsp_ready), 32'd1);
        rsp_valid = 1'b1;
        rsp_hit = mask[pcls];
        rsp_nexthop = 16'hA000 + 16'(pcls);
        pend = 0;
      end
      @(negedge clk);
    end
    rsp_valid = 1'b0;
    probe_ready = 1'b1;
  endtask

  task automatic set_bank(input int b, input logic [1:0] v);
    @(negedge clk);
    bcode_we = 1'b1; bcode_bank = 2'(b); bcode_val = v;
    @(negedge clk);
    bcode_we = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic        fa;
    logic [2:0]  mask;
    logic        hit;
    logic [15:0] nh;
    logic [1:0]  probes;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{32'hC0A8_1234, 1'b0, 3'b001, 1'b1, 16'hA000, 2'd1},
    '{32'h0A00_FF01, 1'b0, 3'b010, 1'b1, 16'hA001, 2'd2},
    '{32'hDEAD_BEEF, 1'b0, 3'b100, 1'b1, 16'hA002, 2'd3},
    '{32'h1234_5678, 1'b0, 3'b000, 1'b0, 16'h0000, 2'd3},
    '{32'hFFFF_FFFF, 1'b0, 3'b011, 1'b1, 16'hA000, 2'd1},
    '{32'h0000_0001, 1'b0, 3'b110, 1'b1, 16'hA001, 2'd2},
    '{32'h8000_0000, 1'b1, 3'b110, 1'b1, 16'hA001, 2'd3},
    '{32'h5A5A_A5A5, 1'b1, 3'b000, 1'b0, 16'h0000, 2'd3},
    '{32'h0F0F_F0F0, 1'b1, 3'b101, 1'b1, 16'hA000, 2'd3}
  };

  initial begin
    logic        h;
    logic [15:0] nh;
    logic [1:0]  pr;
    int          sn;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    chk("R1 reset probe_valid", 32'(probe_valid), 32'd0);
    chk("R6 reset res_valid", 32'(res_valid), 32'd0);
    chk("R12 reset rsp_ready", 32'(rsp_ready), 32'd0);

    // table: R4 early stop, R5 forced walk, R6 miss
    for (int i = 0; i < 9; i++) begin
      run_search(VEC[i].addr, VEC[i].fa, VEC[i].mask, 0, 0, h, nh, pr, sn);
      chk("R4/R5 hit", 32'(h), 32'(VEC[i].hit));
      chk("R4/R5/R6 nexthop", 32'(nh), 32'(VEC[i].nh));
      chk("R4/R5/R6 probes", 32'(pr), 32'(VEC[i].probes));
      chk("R4 probes on stream", 32'(sn), 32'(VEC[i].probes));
    end

    // R10 R11: back-pressure on probe and result in one search
    run_search(32'h7654_3210, 1'b0, 3'b100, 3, 4, h, nh, pr, sn);
    chk("R10 hit after stall", 32'(h), 32'd1);
    chk("R11 nexthop after stall", 32'(nh), 32'hA002);
    chk("R11 probes after stall", 32'(pr), 32'd3);

    // R7: codes 01,01,10,11 -> longest {0,1,3}, shorter {2,3}
    set_bank(0, 2'b01); set_bank(1, 2'b01); set_bank(2, 2'b10); set_bank(3, 2'b11);
    en_long = 4'b1011; en_short = 4'b1100;
    run_search(32'hAB12_CD34, 1'b0, 3'b010, 0, 0, h, nh, pr, sn);
    chk("R7 hit", 32'(h), 32'd1);
    chk("R7 nexthop", 32'(nh), 32'hA001);
    chk("R7 probes", 32'(pr), 32'd2);

    // R8: no bank may hold shorter classes -> skipped, counted, missed
    set_bank(2, 2'b01); set_bank(3, 2'b00);
    en_long = 4'b0111; en_short = 4'b0000;
    run_search(32'h3C3C_3C3C, 1'b0, 3'b110, 0, 0, h, nh, pr, sn);
    chk("R8 skipped classes miss", 32'(h), 32'd0);
    chk("R8 nexthop zero", 32'(nh), 32'd0);
    chk("R8 probes counted", 32'(pr), 32'd3);
    chk("R8 only one probe issued", 32'(sn), 32'd1);
    run_search(32'h1111_2222, 1'b1, 3'b111, 0, 0, h, nh, pr, sn);
    chk("R8 forced hit", 32'(nh), 32'hA000);
    chk("R8 forced probes", 32'(pr), 32'd3);
    chk("R8 forced seen", 32'(sn), 32'd1);

    // R9: restore banks, reprogram class 1 window
    for (int b = 0; b < 4; b++) set_bank(b, 2'b11);
    en_long = 4'b1111; en_short = 4'b1111;
    @(negedge clk);
    ccfg_we = 1'b1; ccfg_sel = 2'd1; ccfg_lo = 6'd18; ccfg_ixlsb = 6'd20; ccfg_hi = 6'd22;
    @(negedge clk);
    ccfg_we = 1'b0;
    b_lo[1] = 18; b_ix[1] = 20; b_hi[1] = 22;
    run_search(32'hF00D_CAFE, 1'b0, 3'b010, 0, 0, h, nh, pr, sn);
    chk("R9 hit new window", 32'(nh), 32'hA001);
    chk("R9 probes", 32'(pr), 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule